// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Unit

This block decides when a small processor core takes a maskable interrupt. Each hardware source raises a request pulse that is latched into a pending bit. Each source also has a 3-bit priority level, supplied from outside the block. A tournament tree picks the pending source with the highest level. That winner is taken only when the global interrupt-enable flag is set and its level is strictly greater than the processor's current level. A level of zero disables a source: it can never be taken, but it stays pending.

When a request is taken, the block does three things in one step. It raises a one-cycle acknowledge carrying the source index, its level and its vector number. It clears that source's pending bit. It updates the flag state: the enable flag and the stack-select flag drop to zero, and the processor level rises to the taken level. The core can also write the three flag fields directly. A software interrupt instruction is reported with its number, and numbers below 32 clear the stack-select flag.

Top module: `irq_accept_unit`

## Requirements
- R1: While reset is held and on leaving it, `ack_o`, `pend_o`, `ipl_o`, `ien_o` and `usel_o` are all zero.
- R2: A high bit of `req_i` sampled at a clock edge sets the matching `pend_o` bit from that edge on. The bit stays set until its source is taken. If a new request for a source arrives in the same cycle that source is taken, the bit stays set.
- R3: A pending source whose level is 0 is never taken and stays pending.
- R4: A request is taken only if its level is strictly greater than `ipl_o`. A level equal to `ipl_o` is not enough.
- R5: While `ien_o` is 0, no request is taken.
- R6: Among pending sources that share the highest level, the one with the lowest index is taken.
- R7: When a request is taken, `ack_o` is high for exactly one cycle, one clock edge after the state that allowed it. Alongside it, `ack_src_o` gives the index, `ack_lvl_o` the level and `ack_vec_o` equals VEC_BASE plus the index. The source's pending bit clears at that same edge.
- R8: At the edge where a request is taken, `ien_o` and `usel_o` go to 0 and `ipl_o` takes the taken level.
- R9: A cycle with `flg_wr_i` high loads `ipl_o`, `ien_o` and `usel_o` from the write fields at the next edge. If a request is taken in the same cycle, the acceptance values of R8 win.
- R10: A cycle with `swi_i` high and `swi_num_i` below 32 leaves `usel_o` at 0 after the next edge, even if a write sets it in the same cycle.
- R11: A software interrupt numbered 32 or more does not change `usel_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Request pulses, one per source |
| prio_i | input | 3*NUM_SRC | Level of each source, 3 bits per source, source k at bits 3k+2..3k |
| flg_wr_i | input | 1 | Write strobe for the flag fields |
| flg_ipl_i | input | 3 | Processor level to write |
| flg_ien_i | input | 1 | Enable flag to write |
| flg_usel_i | input | 1 | Stack-select flag to write |
| swi_i | input | 1 | Software interrupt instruction executes |
| swi_num_i | input | SWI_W | Software interrupt number |
| ack_o | output | 1 | One-cycle acceptance pulse |
| ack_src_o | output | IDX_W | Index of the accepted source |
| ack_lvl_o | output | 3 | Level of the accepted source |
| ack_vec_o | output | VEC_W | Vector number of the accepted source |
| pend_o | output | NUM_SRC | Pending bits |
| ipl_o | output | 3 | Processor priority level |
| ien_o | output | 1 | Interrupt-enable flag |
| usel_o | output | 1 | Stack-select flag |

## Verification
The hardest cases to reach are those where two events meet in the same cycle. One is a taken request that collides with a flag write, where R9 has to override. The other is a new request for the very source being taken, which must leave its pending bit set. Directed sequences stage both. First a request is left pending with the enable flag off. The flag is then turned on by a write, and the colliding write or request is driven in the one cycle where acceptance is live. Random traffic then mixes sparse requests, reprogrammed levels, flag writes and software interrupts around numbers 31 and 32. A reference model in the bench checks the result on every cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // Left operand wins ties, so lower indices win equal levels.
  function automatic logic left_wins(input lvl_t l, input lvl_t r);
    return l >= r;
  endfunction

  // Strictly greater comparison against the processor level.
  function automatic logic outranks(input lvl_t req, input lvl_t cur);
    return req > cur;
  endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    localparam logic [IDX_W-1:0] KIDX = IDX_W'(k);
    logic clr_here;
    assign clr_here = clr_en_i && (clr_idx_i == KIDX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[k] <= 1'b0;
      else        pend_o[k] <= req_i[k] | (pend_o[k] & ~clr_here);
    end
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  output lvl_t                     win_lvl_o,
  output logic [IDX_W-1:0]         win_idx_o
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int NODES  = 2 * LEAVES - 1;

  lvl_t             nd_lvl [NODES];
  logic [IDX_W-1:0] nd_idx [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    localparam int POS = LEAVES - 1 + k;
    if (k < NUM_SRC) begin : g_real
      assign nd_lvl[POS] = pend_i[k] ? prio_i[k*LVL_W +: LVL_W] : '0;
    end else begin : g_pad
      assign nd_lvl[POS] = '0;
    end
    assign nd_idx[POS] = IDX_W'(k);
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic take_left;
    assign take_left  = left_wins(nd_lvl[2*n+1], nd_lvl[2*n+2]);
    assign nd_lvl[n]  = take_left ? nd_lvl[2*n+1] : nd_lvl[2*n+2];
    assign nd_idx[n]  = take_left ? nd_idx[2*n+1] : nd_idx[2*n+2];
  end

  assign win_lvl_o = nd_lvl[0];
  assign win_idx_o = nd_idx[0];
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_accept_pkg::*;
#(
  parameter int SWI_W   = 6,
  parameter int SWI_LIM = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  lvl_t             acc_lvl_i,
  input  logic             wr_i,
  input  lvl_t             wr_ipl_i,
  input  logic             wr_ien_i,
  input  logic             wr_usel_i,
  input  logic             swi_i,
  input  logic [SWI_W-1:0] swi_num_i,
  output lvl_t             ipl_o,
  output logic             ien_o,
  output logic             usel_o
);
  localparam logic [SWI_W:0] LIM = (SWI_W+1)'(SWI_LIM);

  lvl_t ipl_n;
  logic ien_n, usel_n, swi_low;

  assign swi_low = swi_i && ({1'b0, swi_num_i} < LIM);

  // Order: direct write, then software interrupt, then acceptance.
  always_comb begin
    ipl_n  = ipl_o;
    ien_n  = ien_o;
    usel_n = usel_o;
    if (wr_i) begin
      ipl_n  = wr_ipl_i;
      ien_n  = wr_ien_i;
      usel_n = wr_usel_i;
    end
    if (swi_low) usel_n = 1'b0;
    if (accept_i) begin
      ipl_n  = acc_lvl_i;
      ien_n  = 1'b0;
      usel_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl_o  <= '0;
      ien_o  <= 1'b0;
      usel_o <= 1'b0;
    end else begin
      ipl_o  <= ipl_n;
      ien_o  <= ien_n;
      usel_o <= usel_n;
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int SWI_W    = 6,
  parameter int SWI_LIM  = 32,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  logic                     flg_wr_i,
  input  logic [LVL_W-1:0]         flg_ipl_i,
  input  logic                     flg_ien_i,
  input  logic                     flg_usel_i,
  input  logic                     swi_i,
  input  logic [SWI_W-1:0]         swi_num_i,
  output logic                     ack_o,
  output logic [IDX_W-1:0]         ack_src_o,
  output logic [LVL_W-1:0]         ack_lvl_o,
  output logic [VEC_W-1:0]         ack_vec_o,
  output logic [NUM_SRC-1:0]       pend_o,
  output logic [LVL_W-1:0]         ipl_o,
  output logic                     ien_o,
  output logic                     usel_o
);
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] s);
    return VEC_W'(VEC_BASE) + VEC_W'(s);
  endfunction

  // Named internal events, visible to the checker.
  lvl_t             win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic             accept_w;

  irq_pending_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .clr_en_i(accept_w), .clr_idx_i(win_idx), .pend_o(pend_o)
  );

  irq_prio_tree #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_tree (
    .pend_i(pend_o), .prio_i(prio_i),
    .win_lvl_o(win_lvl), .win_idx_o(win_idx)
  );

  assign accept_w = ien_o && outranks(win_lvl, ipl_o);

  irq_flag_ctrl #(.SWI_W(SWI_W), .SWI_LIM(SWI_LIM)) u_flg (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .acc_lvl_i(win_lvl),
    .wr_i(flg_wr_i), .wr_ipl_i(flg_ipl_i), .wr_ien_i(flg_ien_i),
    .wr_usel_i(flg_usel_i), .swi_i(swi_i), .swi_num_i(swi_num_i),
    .ipl_o(ipl_o), .ien_o(ien_o), .usel_o(usel_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o     <= 1'b0;
      ack_src_o <= '0;
      ack_lvl_o <= '0;
      ack_vec_o <= '0;
    end else begin
      ack_o <= accept_w;
      if (accept_w) begin
        ack_src_o <= win_idx;
        ack_lvl_o <= win_lvl;
        ack_vec_o <= vec_of(win_idx);
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4,
  parameter int SWI_W   = 6,
  parameter int SWI_LIM = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic               flg_wr_i,
  input logic               swi_i,
  input logic [SWI_W-1:0]   swi_num_i,
  input logic               ack_o,
  input logic [IDX_W-1:0]   ack_src_o,
  input logic [2:0]         ack_lvl_o,
  input logic [NUM_SRC-1:0] pend_o,
  input logic [2:0]         ipl_o,
  input logic               ien_o,
  input logic               usel_o,
  input logic               accept_w
);
  localparam logic [SWI_W:0] LIM = (SWI_W+1)'(SWI_LIM);

  a_r1_no_ack_in_reset: assert property (@(posedge clk) !rst_n |=> !ack_o || !rst_n);

  a_r2_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (!pend_o[ack_src_o] || ((($past(req_i) >> ack_src_o) & 1) != 0)));

  a_r3_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ack_lvl_o != 3'd0);

  a_r4_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ack_lvl_o > $past(ipl_o));

  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(ien_o));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  a_r8_flags_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (ipl_o == ack_lvl_o && !ien_o && !usel_o));

  a_r10_swi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_i && {1'b0, swi_num_i} < LIM) |=> !usel_o);

  a_r11_swi_high_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_i && {1'b0, swi_num_i} >= LIM && !flg_wr_i && !accept_w) |=> $stable(usel_o));
endmodule

bind irq_accept_unit irq_accept_unit_chk #(
  .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .SWI_W(SWI_W), .SWI_LIM(SWI_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .flg_wr_i(flg_wr_i),
  .swi_i(swi_i), .swi_num_i(swi_num_i), .ack_o(ack_o),
  .ack_src_o(ack_src_o), .ack_lvl_o(ack_lvl_o), .pend_o(pend_o),
  .ipl_o(ipl_o), .ien_o(ien_o), .usel_o(usel_o), .accept_w(accept_w)
);

// File: tb/irq_accept_unit_bench.sv
module irq_accept_unit_bench;
  localparam int N    = 16;
  localparam int IW   = 4;
  localparam int VW   = 8;
  localparam int VB   = 16;
  localparam int SW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [2:0] prio_b [N];
  logic [N*3-1:0] prio_i;
  logic flg_wr_i = 1'b0, flg_ien_i = 1'b0, flg_usel_i = 1'b0;
  logic [2:0] flg_ipl_i = '0;
  logic swi_i = 1'b0;
  logic [SW-1:0] swi_num_i = '0;
  logic ack_o, ien_o, usel_o;
  logic [IW-1:0] ack_src_o;
  logic [2:0] ack_lvl_o, ipl_o;
  logic [VW-1:0] ack_vec_o;
  logic [N-1:0] pend_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int k = 0; k < N; k++) prio_i[k*3 +: 3] = prio_b[k];

  irq_accept_unit u_irq_accept_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
    .flg_wr_i(flg_wr_i), .flg_ipl_i(flg_ipl_i), .flg_ien_i(flg_ien_i),
    .flg_usel_i(flg_usel_i), .swi_i(swi_i), .swi_num_i(swi_num_i),
    .ack_o(ack_o), .ack_src_o(ack_src_o), .ack_lvl_o(ack_lvl_o),
    .ack_vec_o(ack_vec_o), .pend_o(pend_o), .ipl_o(ipl_o),
    .ien_o(ien_o), .usel_o(usel_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: scan levels from high to low, indices from low to high.
  function automatic logic [7:0] best_of(input logic [N-1:0] p);
    for (int lv = 7; lv >= 1; lv--)
      for (int i = 0; i < N; i++)
        if (p[i] && prio_b[i] == 3'(lv)) return {1'b1, 3'(lv), 4'(i)};
    return 8'h0;
  endfunction

  logic [N-1:0] m_pend = '0;
  logic [2:0] m_ipl = '0, m_lvl = '0;
  logic m_ien = 0, m_usel = 0, m_ack = 0;
  logic [IW-1:0] m_src = '0;

  always @(posedge clk) begin
    logic [7:0] b;
    logic take;
    if (!rst_n) begin
      m_pend <= '0; m_ipl <= '0; m_ien <= 0; m_usel <= 0; m_ack <= 0;
    end else begin
      b = best_of(m_pend);
      take = m_ien && b[7] && (b[6:4] > m_ipl);
      m_ack <= take;
      if (take) begin m_src <= b[3:0]; m_lvl <= b[6:4]; end
      m_pend <= (m_pend & ~(take ? (N'(1) << b[3:0]) : '0)) | req_i;
      if (take) begin
        m_ipl <= b[6:4]; m_ien <= 0; m_usel <= 0;
      end else begin
        m_ipl <= flg_wr_i ? flg_ipl_i : m_ipl;
        m_ien <= flg_wr_i ? flg_ien_i : m_ien;
        if (swi_i && swi_num_i < 6'd32) m_usel <= 0;
        else if (flg_wr_i) m_usel <= flg_usel_i;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 ack_o", ack_o, m_ack);
      if (m_ack) begin
        chk("R6 ack_src_o", ack_src_o, m_src);
        chk("R4 ack_lvl_o", ack_lvl_o, m_lvl);
        chk("R7 ack_vec_o", ack_vec_o, VB + m_src);
      end
      chk("R8 ipl_o", ipl_o, m_ipl);
      chk("R8 ien_o", ien_o, m_ien);
      chk("R10 usel_o", usel_o, m_usel);
      chk("R2 pend_o", pend_o, m_pend);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr_flags(input int ipl, input bit ien, input bit usel);
    flg_wr_i = 1; flg_ipl_i = 3'(ipl); flg_ien_i = ien; flg_usel_i = usel;
    step();
    flg_wr_i = 0;
  endtask

  task automatic pulse_req(input int k);
    req_i = N'(1) << k;
    step();
    req_i = '0;
  endtask

  task automatic swi(input int num);
    swi_i = 1; swi_num_i = SW'(num);
    step();
    swi_i = 0;
  endtask

  initial begin
    void'($urandom(32'd20240613));
    for (int k = 0; k < N; k++) prio_b[k] = 3'd0;
    repeat (3) step();
    // R1: reset state
    chk("R1 ack_o", ack_o, 0);
    chk("R1 pend_o", pend_o, 0);
    chk("R1 flags", {ipl_o, ien_o, usel_o}, 0);
    rst_n = 1;
    step();
    chk("R1 after release", {ack_o, ipl_o, ien_o, usel_o}, 0);

    // R5: enable flag off blocks acceptance
    prio_b[3] = 3'd5;
    wr_flags(0, 0, 1);
    pulse_req(3);
    step(); step();
    chk("R5 no ack while disabled", ack_o, 0);
    chk("R5 source stays pending", pend_o[3], 1);

    // R4: equal level not enough, then one above
    wr_flags(5, 1, 1);
    step();
    chk("R4 equal level rejected", ack_o, 0);
    wr_flags(4, 1, 1);
    step();
    chk("R4 ack when above", ack_o, 1);
    chk("R7 src", ack_src_o, 3);
    chk("R7 vec", ack_vec_o, VB + 3);
    chk("R7 pending cleared", pend_o[3], 0);
    chk("R8 ipl raised", ipl_o, 5);
    chk("R8 ien cleared", ien_o, 0);
    chk("R8 usel cleared", usel_o, 0);
    step();
    chk("R7 one-cycle pulse", ack_o, 0);

    // R6: tie goes to lowest index
    prio_b[2] = 3'd6; prio_b[5] = 3'd6;
    req_i = (N'(1) << 2) | (N'(1) << 5);
    wr_flags(0, 1, 1);
    req_i = '0;
    step();
    chk("R6 tie lowest index", ack_src_o, 2);
    chk("R6 other still pending", pend_o[5], 1);
    wr_flags(0, 1, 1);
    step();
    chk("R6 second winner", ack_src_o, 5);

    // R3: level 0 never taken
    prio_b[7] = 3'd0;
    wr_flags(0, 1, 0);
    pulse_req(7);
    step(); step();
    chk("R3 no ack for level 0", ack_o, 0);
    chk("R3 still pending", pend_o[7], 1);
    prio_b[7] = 3'd1;
    step();
    chk("R3 taken once enabled", ack_src_o, 7);

    // R2: new request in the same cycle as acceptance keeps the bit
    prio_b[9] = 3'd2;
    wr_flags(0, 1, 0);
    pulse_req(9);
    pulse_req(9);
    chk("R2 accepted", {ack_o, ack_src_o}, {1'b1, 4'd9});
    chk("R2 bit kept by new request", pend_o[9], 1);

    // R9 plain write, R10 / R11 software interrupts
    wr_flags(6, 0, 1);
    chk("R9 ipl loaded", ipl_o, 6);
    chk("R9 usel loaded", usel_o, 1);
    swi(40);
    chk("R11 swi 40 keeps usel", usel_o, 1);
    swi(32);
    chk("R11 swi 32 keeps usel", usel_o, 1);
    swi(31);
    chk("R10 swi 31 clears usel", usel_o, 0);
    wr_flags(6, 0, 1);
    swi(0);
    chk("R10 swi 0 clears usel", usel_o, 0);

    // R9: acceptance overrides a write in the same cycle
    prio_b[11] = 3'd4;
    pulse_req(11);
    wr_flags(0, 1, 1);
    wr_flags(7, 1, 1);
    chk("R9 ack wins", ack_src_o, 11);
    chk("R9 ipl from accept", ipl_o, 4);
    chk("R9 ien from accept", ien_o, 0);
    chk("R9 usel from accept", usel_o, 0);

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      if (c % 200 == 0)
        for (int k = 0; k < N; k++) prio_b[k] = 3'($urandom_range(0, 7));
      req_i = N'($urandom & $urandom & $urandom);
      flg_wr_i = ($urandom_range(0, 7) == 0);
      flg_ipl_i = 3'($urandom_range(0, 5));
      flg_ien_i = ($urandom_range(0, 3) != 0);
      flg_usel_i = 1'($urandom);
      swi_i = ($urandom_range(0, 9) == 0);
      swi_num_i = ($urandom_range(0, 1) == 0) ? SW'($urandom_range(30, 33)) : SW'($urandom);
      step();
    end
    req_i = '0; flg_wr_i = 0; swi_i = 0;
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule